// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits on the write side of a byte-wide non-volatile memory controller. It watches every bus write (address and byte) and picks out the multi-write unlock sequences that guard the array. All commands begin with the same two keyed writes. A third write either completes a short command or opens a longer branch that needs three more writes. From these sequences the block keeps a global write-protection flag and an identification-mode flag. It opens a page-load window and issues a one-cycle chip-erase start.

Writes that are not part of a command are plain data writes. Such a write is forwarded on the pass port only when protection is off or a page-load window is open. A data write made while protected and without a window is refused. It then locks the block out for a fixed number of cycles, and every write in that period is ignored. In identification mode, reads of the two lowest addresses return the identity bytes. The page buffer, its timing and the array itself live elsewhere.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, prot_on, page_grant, id_mode, busy, wr_pass, erase_start and id_valid are all 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h set prot_on and open page_grant after the third write. prot_on stays 1 after the window closes.
- R3: While page_grant is 1, every write is forwarded (wr_pass=1 in the following cycle, with pass_addr/pass_data) and restarts the window. The window closes LOAD_GAP cycles after the last write, so a write LOAD_GAP cycles after the previous one is still forwarded and one a cycle later is not.
- R4: Prefix, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears prot_on.
- R5: The same six-write path ending in 10h@5555h raises erase_start for exactly one cycle.
- R6: Prefix with 90h@5555h, or the six-write path ending in 60h@5555h, sets id_mode. Prefix with F0h@5555h clears it.
- R7: A read in id_mode returns id_valid=1 the next cycle, with id_data BFh for address 0 and 5Dh for address 1. Other addresses, and reads outside id_mode, give id_valid=0.
- R8: Address bit 15 is ignored for command matching and is not forwarded (pass_addr is bits 14..0).
- R9: With protection off, a write that is not a command step is forwarded on wr_pass.
- R10: A data write while protected and without a window is not forwarded and sets busy for LOCK_CYCLES cycles. Writes during busy are ignored, so command writes there change no flag.
- R11: A write that does not match the expected next step returns the decoder to idle. That write is not reinterpreted as a command, so a following A0h@5555h is plain data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 16 | Bus address; bit 15 ignored |
| wdata | input | 8 | Write data |
| prot_on | output | 1 | Global write protection active |
| page_grant | output | 1 | Page-load window open |
| erase_start | output | 1 | One-cycle chip erase start |
| id_mode | output | 1 | Identification mode active |
| busy | output | 1 | Lockout after a refused write |
| wr_pass | output | 1 | Forwarded data write, one cycle |
| pass_addr | output | 15 | Address of the forwarded write |
| pass_data | output | 8 | Data of the forwarded write |
| id_valid | output | 1 | Identification byte valid |
| id_data | output | 8 | Identification byte |

## Verification
Two events can meet on one clock edge: the page-load window running out, and a new data write arriving. The bench opens a window and waits exactly LOAD_GAP-1 idle cycles. The next write then lands on the window's last cycle, and it must be forwarded and reopen the window. In a second run the bench waits one cycle longer. That write must be refused and start the lockout, and protection must stay on in both runs.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  localparam int unsigned AW = 15;
  localparam int unsigned DW = 8;

  localparam logic [AW-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [AW-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [DW-1:0] KEY_BYTE_A = 8'hAA;
  localparam logic [DW-1:0] KEY_BYTE_B = 8'h55;

  localparam logic [DW-1:0] OP_LOCK_PAGE = 8'hA0;
  localparam logic [DW-1:0] OP_EXTEND    = 8'h80;
  localparam logic [DW-1:0] OP_ID_ENTER  = 8'h90;
  localparam logic [DW-1:0] OP_ID_LEAVE  = 8'hF0;
  localparam logic [DW-1:0] OP_UNLOCK    = 8'h20;
  localparam logic [DW-1:0] OP_ERASE     = 8'h10;
  localparam logic [DW-1:0] OP_ID_ALT    = 8'h60;

  localparam logic [DW-1:0] ID_BYTE_LO = 8'hBF;
  localparam logic [DW-1:0] ID_BYTE_HI = 8'h5D;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_X3, ST_X4, ST_X5
  } seq_st_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_PROT_ON, CMD_PROT_OFF, CMD_ERASE, CMD_ID_ON, CMD_ID_OFF
  } cmd_t;
endpackage

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          hit,
  output cmd_t          cmd
);
  seq_st_t st, st_nxt;
  logic at_a, at_b;

  assign at_a = (addr == KEY_ADDR_A);
  assign at_b = (addr == KEY_ADDR_B);

  always_comb begin
    st_nxt = st;
    cmd    = CMD_NONE;
    hit    = 1'b0;
    if (step_en) begin
      st_nxt = ST_IDLE;
      case (st)
        ST_IDLE, ST_X3: if (at_a && data == KEY_BYTE_A) begin
          st_nxt = (st == ST_IDLE) ? ST_K1 : ST_X4;
          hit    = 1'b1;
        end
        ST_K1, ST_X4: if (at_b && data == KEY_BYTE_B) begin
          st_nxt = (st == ST_K1) ? ST_K2 : ST_X5;
          hit    = 1'b1;
        end
        ST_K2: if (at_a) begin
          hit = 1'b1;
          case (data)
            OP_LOCK_PAGE: cmd = CMD_PROT_ON;
            OP_EXTEND:    st_nxt = ST_X3;
            OP_ID_ENTER:  cmd = CMD_ID_ON;
            OP_ID_LEAVE:  cmd = CMD_ID_OFF;
            default:      hit = 1'b0;
          endcase
        end
        ST_X5: if (at_a) begin
          hit = 1'b1;
          case (data)
            OP_UNLOCK: cmd = CMD_PROT_OFF;
            OP_ERASE:  cmd = CMD_ERASE;
            OP_ID_ALT: cmd = CMD_ID_ON;
            default:   hit = 1'b0;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  // R11: a mismatching step sends the decoder back to idle
  a_r11_break_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !hit) |=> (st == ST_IDLE));
endmodule

// File: rtl/cmd_hold_timer.sv
module cmd_hold_timer #(
  parameter int unsigned LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt;
    if (load)             cnt_nxt = CW'(LEN);
    else if (cnt != '0)   cnt_nxt = cnt - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  assign active = (cnt != '0);
endmodule

// File: rtl/cmd_id_reader.sv
module cmd_id_reader
  import cmd_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic          id_mode,
  input  logic [AW-1:0] addr,
  output logic          id_valid,
  output logic [DW-1:0] id_data
);
  logic          hit;
  logic [DW-1:0] byte_sel;

  assign hit      = rd_en && id_mode && (addr[AW-1:1] == '0);
  assign byte_sel = addr[0] ? ID_BYTE_HI : ID_BYTE_LO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_valid <= 1'b0;
      id_data  <= '0;
    end else begin
      id_valid <= hit;
      id_data  <= hit ? byte_sel : '0;
    end
  end

  // R7: identity bytes only appear for reads made in identification mode
  a_r7_id_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> $past(id_mode));
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
  import cmd_seq_pkg::*;
#(
  parameter int unsigned LOAD_GAP    = 8,
  parameter int unsigned LOCK_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [15:0]   addr,
  input  logic [7:0]    wdata,
  output logic          prot_on,
  output logic          page_grant,
  output logic          erase_start,
  output logic          id_mode,
  output logic          busy,
  output logic          wr_pass,
  output logic [14:0]   pass_addr,
  output logic [7:0]    pass_data,
  output logic          id_valid,
  output logic [7:0]    id_data
);
  logic [1:0]    rst_sync;
  logic          rst_i_n;
  logic [AW-1:0] a_lo;
  logic          unused_a15;
  logic          wr_live, step_en, hit, data_wr, accept, reject, grant_load;
  cmd_t          cmd;
  logic          prot_nxt, id_nxt;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  assign a_lo       = addr[AW-1:0];
  assign unused_a15 = addr[15];

  assign wr_live    = wr_en && !busy;
  assign step_en    = wr_live && !page_grant;
  assign data_wr    = wr_live && (page_grant || !hit);
  assign accept     = data_wr && (page_grant || !prot_on);
  assign reject     = data_wr && !accept;
  assign grant_load = (cmd == CMD_PROT_ON) || (page_grant && wr_live);

  cmd_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .step_en(step_en),
    .addr(a_lo), .data(wdata), .hit(hit), .cmd(cmd)
  );

  cmd_hold_timer #(.LEN(LOAD_GAP)) u_grant (
    .clk(clk), .rst_n(rst_i_n), .load(grant_load), .active(page_grant)
  );

  cmd_hold_timer #(.LEN(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst_n(rst_i_n), .load(reject), .active(busy)
  );

  cmd_id_reader u_id (
    .clk(clk), .rst_n(rst_i_n), .rd_en(rd_en), .id_mode(id_mode),
    .addr(a_lo), .id_valid(id_valid), .id_data(id_data)
  );

  always_comb begin
    prot_nxt = prot_on;
    id_nxt   = id_mode;
    if (cmd == CMD_PROT_ON)  prot_nxt = 1'b1;
    if (cmd == CMD_PROT_OFF) prot_nxt = 1'b0;
    if (cmd == CMD_ID_ON)    id_nxt   = 1'b1;
    if (cmd == CMD_ID_OFF)   id_nxt   = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      prot_on     <= 1'b0;
      id_mode     <= 1'b0;
      erase_start <= 1'b0;
      wr_pass     <= 1'b0;
      pass_addr   <= '0;
      pass_data   <= '0;
    end else begin
      prot_on     <= prot_nxt;
      id_mode     <= id_nxt;
      erase_start <= (cmd == CMD_ERASE);
      wr_pass     <= accept;
      if (accept) begin
        pass_addr <= a_lo;
        pass_data <= wdata;
      end
    end
  end

  // R2: a page-load window only exists under protection
  a_r2_grant_needs_prot: assert property (@(posedge clk) disable iff (!rst_i_n)
    page_grant |-> prot_on);
  // R3: a forwarded write had a window or no protection when it arrived
  a_r3_pass_authorised: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr_pass |-> ($past(page_grant) || !$past(prot_on)));
  // R5: erase start is a single-cycle pulse
  a_r5_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_i_n)
    erase_start |=> !erase_start);
  // R10: nothing is forwarded while the lockout runs
  a_r10_busy_blocks_pass: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> !wr_pass);
endmodule

// File: tb/cmd_seq_decoder_test.sv
module cmd_seq_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP  = 8;
  localparam int LOCK = 16;

  logic        clk = 1'b0;
  logic        rst_n, wr_en, rd_en;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        prot_on, page_grant, erase_start, id_mode, busy, wr_pass, id_valid;
  logic [14:0] pass_addr;
  logic [7:0]  pass_data, id_data;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_seq_decoder #(.LOAD_GAP(GAP), .LOCK_CYCLES(LOCK)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .prot_on(prot_on), .page_grant(page_grant),
    .erase_start(erase_start), .id_mode(id_mode), .busy(busy),
    .wr_pass(wr_pass), .pass_addr(pass_addr), .pass_data(pass_data),
    .id_valid(id_valid), .id_data(id_data)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic prefix();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic long_cmd(input logic [7:0] op);
    prefix();
    wr(16'h5555, 8'h80);
    prefix();
    wr(16'h5555, op);
  endtask

  task automatic t_reset();
    check("R1 prot_on", prot_on, 0);
    check("R1 page_grant", page_grant, 0);
    check("R1 id_mode", id_mode, 0);
    check("R1 busy", busy, 0);
    check("R1 wr_pass", wr_pass, 0);
    check("R1 erase_start", erase_start, 0);
  endtask

  task automatic t_plain();
    wr(16'h0100, 8'h12);
    check("R9 pass", wr_pass, 1);
    check("R9 data", pass_data, 8'h12);
    wr(16'h8123, 8'h34);
    check("R8 addr bit15 dropped", pass_addr, 15'h0123);
    idle(1);
    check("R9 pass pulse ends", wr_pass, 0);
  endtask

  task automatic t_break();
    prefix();
    wr(16'h1234, 8'h33);
    check("R11 breaking write passes", wr_pass, 1);
    wr(16'h5555, 8'hA0);
    check("R11 lone A0 is data", wr_pass, 1);
    check("R11 no enable", prot_on, 0);
  endtask

  task automatic t_id();
    prefix();
    wr(16'hD555, 8'h90);
    check("R6 R8 enter id", id_mode, 1);
    rd(16'h0000);
    check("R7 valid a0", id_valid, 1);
    check("R7 byte a0", id_data, 8'hBF);
    rd(16'h0001);
    check("R7 byte a1", id_data, 8'h5D);
    rd(16'h0002);
    check("R7 other addr", id_valid, 0);
    prefix();
    wr(16'h5555, 8'hF0);
    check("R6 exit id", id_mode, 0);
    rd(16'h0000);
    check("R7 no id outside mode", id_valid, 0);
    long_cmd(8'h60);
    check("R6 six-write id entry", id_mode, 1);
    prefix();
    wr(16'h5555, 8'hF0);
    check("R6 exit again", id_mode, 0);
  endtask

  task automatic t_enable();
    prefix();
    wr(16'h5555, 8'hA0);
    check("R2 prot on", prot_on, 1);
    check("R2 grant", page_grant, 1);
    wr(16'h0280, 8'h5A);
    check("R3 load passes", wr_pass, 1);
    idle(GAP - 1);
    wr(16'h0281, 8'hC3);
    check("R3 write on last window cycle passes", wr_pass, 1);
    check("R3 window reopened", page_grant, 1);
    idle(GAP);
    check("R3 window closed", page_grant, 0);
    check("R2 prot stays on", prot_on, 1);
  endtask

  task automatic t_reject();
    wr(16'h0200, 8'h77);
    check("R10 not passed", wr_pass, 0);
    check("R10 busy", busy, 1);
    prefix();
    wr(16'h5555, 8'h90);
    check("R10 command ignored in lockout", id_mode, 0);
    idle(LOCK - 4);
    check("R10 busy last cycle", busy, 1);
    idle(1);
    check("R10 busy ends", busy, 0);
  endtask

  task automatic t_late();
    prefix();
    wr(16'h5555, 8'hA0);
    idle(GAP);
    check("R3 window gone", page_grant, 0);
    wr(16'h0300, 8'h11);
    check("R3 late write refused", wr_pass, 0);
    check("R10 late write locks", busy, 1);
    idle(LOCK);
  endtask

  task automatic t_erase();
    long_cmd(8'h10);
    check("R5 erase pulse", erase_start, 1);
    idle(1);
    check("R5 pulse one cycle", erase_start, 0);
    check("R5 prot unchanged", prot_on, 1);
  endtask

  task automatic t_disable();
    long_cmd(8'h20);
    check("R4 prot off", prot_on, 0);
    wr(16'h0400, 8'h99);
    check("R4 R9 data passes after unlock", wr_pass, 1);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_plain();
    t_break();
    t_id();
    t_enable();
    t_reject();
    t_late();
    t_erase();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule